// File: doc/BRIEF.md
# Multi-Engine Match Priority Resolver

This block turns the outputs of three lookup engines, which search in parallel, into one forwarding decision per packet. The three engines are a longest-prefix route lookup, an exact five-tuple flow lookup, and a wildcard filter lookup. The wildcard engine can report two hits at once: an exclusive filter and a non-exclusive filter. Each hit arrives as a hit flag with an action. The action is an output-port number, a queue identifier and the index of the table entry that matched. Every wildcard hit also carries its own 6-bit priority. All route entries share one priority and all flow entries share one priority. Those two values are parameters of the block.

The resolver picks a single exclusive winner. It marks the packet for drop when nothing matched. A non-exclusive wildcard hit always adds one extra header copy, with its own port and queue. The block reports the total number of copies.

The block also drives one increment strobe and entry index per engine for the match counters, which sit outside it. Each engine follows its own rule for when it counts:
- Route and flow entries count on every match, one cycle after the result set arrives, before the winner is known.
- The exclusive wildcard filter counts only when it wins, and the strobe comes out with the decision.
- The non-exclusive filter counts whenever it is applied.

A new result set can be accepted on every cycle.

Top module: `match_resolver`

## Requirements
- R1: A result set presented with `in_valid` high yields `dec_valid` high exactly two clock cycles later. One set is accepted per cycle with no stall, and `dec_valid` stays low for cycles without a result set.
- R2: Among the valid exclusive candidates, the numerically lowest priority wins, where 0 is the most urgent. A route hit carries priority `ROUTE_PRIO`, a flow hit carries `FLOW_PRIO`, and an exclusive wildcard hit carries `wx_prio`.
- R3: When exclusive candidates have equal priority, the wildcard filter beats the flow entry, and the flow entry beats the route entry.
- R4: `dec_src` identifies the winner: 0 means none, 1 route, 2 flow, 3 exclusive wildcard. When `dec_src` is not 0, `dec_port` and `dec_qid` carry the winner's port and queue identifier.
- R5: A valid non-exclusive wildcard hit sets `aux_valid` with `aux_port`/`aux_qid` taken from that hit, whatever the priorities are. `dec_copies` equals (1 if `dec_src` is not 0) plus (1 if `aux_valid`).
- R6: If no candidate at all is valid, the decision has `dec_drop` = 1, `dec_src` = 0, `dec_copies` = 0 and `aux_valid` = 0.
- R7: If only the non-exclusive hit is valid, the decision has `dec_drop` = 0, `dec_src` = 0 and `dec_copies` = 1.
- R8: `cnt_rt_inc`/`cnt_fl_inc` pulse with the entry index exactly one cycle after a route/flow hit, whether or not that entry wins.
- R9: `cnt_wx_inc` pulses with `cnt_wx_idx` in the same cycle as the decision, and only when the exclusive wildcard filter is the winner.
- R10: `cnt_wn_inc` pulses with `cnt_wn_idx` in the same cycle as the decision whenever a non-exclusive hit is applied.
- R11: Hit flags presented while `in_valid` is low have no effect: no counter strobe and no decision.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A result set is present this cycle |
| rt_hit | input | 1 | Route lookup matched |
| rt_port | input | PORT_W | Route action output port |
| rt_qid | input | QID_W | Route action queue identifier |
| rt_idx | input | IDX_W | Matched route entry index |
| fl_hit | input | 1 | Flow lookup matched |
| fl_port | input | PORT_W | Flow action output port |
| fl_qid | input | QID_W | Flow action queue identifier |
| fl_idx | input | IDX_W | Matched flow entry index |
| wx_hit | input | 1 | Exclusive wildcard filter matched |
| wx_prio | input | PRIO_W | Priority of the exclusive wildcard filter |
| wx_port | input | PORT_W | Exclusive wildcard output port |
| wx_qid | input | QID_W | Exclusive wildcard queue identifier |
| wx_idx | input | IDX_W | Exclusive wildcard filter index |
| wn_hit | input | 1 | Non-exclusive wildcard filter matched |
| wn_port | input | PORT_W | Non-exclusive copy output port |
| wn_qid | input | QID_W | Non-exclusive copy queue identifier |
| wn_idx | input | IDX_W | Non-exclusive filter index |
| dec_valid | output | 1 | Decision present |
| dec_drop | output | 1 | Packet matched nothing and is dropped |
| dec_src | output | 2 | Winning engine (0 none, 1 route, 2 flow, 3 wildcard) |
| dec_copies | output | 2 | Number of header copies sent to queuing |
| dec_port | output | PORT_W | Winner output port |
| dec_qid | output | QID_W | Winner queue identifier |
| aux_valid | output | 1 | Extra copy for the non-exclusive hit |
| aux_port | output | PORT_W | Extra copy output port |
| aux_qid | output | QID_W | Extra copy queue identifier |
| cnt_rt_inc | output | 1 | Route counter increment strobe |
| cnt_rt_idx | output | IDX_W | Route counter index |
| cnt_fl_inc | output | 1 | Flow counter increment strobe |
| cnt_fl_idx | output | IDX_W | Flow counter index |
| cnt_wx_inc | output | 1 | Exclusive wildcard counter increment strobe |
| cnt_wx_idx | output | IDX_W | Exclusive wildcard counter index |
| cnt_wn_inc | output | 1 | Non-exclusive wildcard counter increment strobe |
| cnt_wn_idx | output | IDX_W | Non-exclusive wildcard counter index |

## Verification
A comparator that orders the candidates wrongly, for example by reversing the tie rank or the compare direction, shows up in the very next decision. It appears as a wrong `dec_src` together with the losing engine's port and queue. A mis-staged pipeline shows up instead as a counter strobe or a decision one cycle early or late. The route and flow strobes must lead the decision by exactly one cycle, so any slip in either stage breaks that fixed offset. A stale non-exclusive flag, or a wrong copy total, is visible in `dec_copies` and `aux_valid` on the same cycle as the decision it belongs to.

// File: rtl/mr_pkg.sv
package mr_pkg;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_ROUTE = 2'd1,
      SRC_FLOW  = 2'd2,
      SRC_WILD  = 2'd3
   } mr_src_e;

   // Exclusive candidate slots; a lower slot wins ties.
   localparam int unsigned N_EXCL     = 3;
   localparam int unsigned SLOT_WILD  = 0;
   localparam int unsigned SLOT_FLOW  = 1;
   localparam int unsigned SLOT_ROUTE = 2;

endpackage

// File: rtl/mr_pipe.sv
module mr_pipe #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/mr_pick.sv
// Minimum-key selector over N candidates; lower slot index wins a tie.
module mr_pick #(
   parameter  int N     = 3,
   parameter  int KEY_W = 6,
   parameter  int PAY_W = 8,
   localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]       vld,
   input  logic [N*KEY_W-1:0] key,
   input  logic [N*PAY_W-1:0] pay,
   output logic               any,
   output logic [SEL_W-1:0]   sel,
   output logic [PAY_W-1:0]   win_pay
);

   logic [N-1:0] win_oh;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         win_oh[i] = vld[i];
         for (int j = 0; j < N; j++) begin
            if (j != i && vld[j]) begin
               if (key[j*KEY_W +: KEY_W] < key[i*KEY_W +: KEY_W])
                  win_oh[i] = 1'b0;
               else if (key[j*KEY_W +: KEY_W] == key[i*KEY_W +: KEY_W] && j < i)
                  win_oh[i] = 1'b0;
            end
         end
      end
   end

   always_comb begin
      any     = |vld;
      sel     = '0;
      win_pay = '0;
      for (int i = 0; i < N; i++) begin
         if (win_oh[i]) begin
            sel     = SEL_W'(i);
            win_pay = pay[i*PAY_W +: PAY_W];
         end
      end
   end

endmodule

// File: rtl/match_resolver.sv
module match_resolver
   import mr_pkg::*;
#(
   parameter int PRIO_W     = 6,
   parameter int PORT_W     = 3,
   parameter int QID_W      = 9,
   parameter int IDX_W      = 6,
   parameter int ROUTE_PRIO = 40,
   parameter int FLOW_PRIO  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              rt_hit,
   input  logic [PORT_W-1:0] rt_port,
   input  logic [QID_W-1:0]  rt_qid,
   input  logic [IDX_W-1:0]  rt_idx,
   input  logic              fl_hit,
   input  logic [PORT_W-1:0] fl_port,
   input  logic [QID_W-1:0]  fl_qid,
   input  logic [IDX_W-1:0]  fl_idx,
   input  logic              wx_hit,
   input  logic [PRIO_W-1:0] wx_prio,
   input  logic [PORT_W-1:0] wx_port,
   input  logic [QID_W-1:0]  wx_qid,
   input  logic [IDX_W-1:0]  wx_idx,
   input  logic              wn_hit,
   input  logic [PORT_W-1:0] wn_port,
   input  logic [QID_W-1:0]  wn_qid,
   input  logic [IDX_W-1:0]  wn_idx,
   output logic              dec_valid,
   output logic              dec_drop,
   output logic [1:0]        dec_src,
   output logic [1:0]        dec_copies,
   output logic [PORT_W-1:0] dec_port,
   output logic [QID_W-1:0]  dec_qid,
   output logic              aux_valid,
   output logic [PORT_W-1:0] aux_port,
   output logic [QID_W-1:0]  aux_qid,
   output logic              cnt_rt_inc,
   output logic [IDX_W-1:0]  cnt_rt_idx,
   output logic              cnt_fl_inc,
   output logic [IDX_W-1:0]  cnt_fl_idx,
   output logic              cnt_wx_inc,
   output logic [IDX_W-1:0]  cnt_wx_idx,
   output logic              cnt_wn_inc,
   output logic [IDX_W-1:0]  cnt_wn_idx
);

   localparam int ACT_W = PORT_W + QID_W;
   localparam int SEL_W = $clog2(N_EXCL);
   localparam int RF_W  = 2 + 2 * IDX_W;
   localparam int S1_W  = 1 + 2 + ACT_W + 1 + ACT_W + 2 * (1 + IDX_W);
   localparam int S2_W  = 1 + 1 + 2 + 2 + ACT_W + 1 + ACT_W + 2 * (1 + IDX_W);
   localparam logic [PRIO_W-1:0] RT_KEY = PRIO_W'(ROUTE_PRIO);
   localparam logic [PRIO_W-1:0] FL_KEY = PRIO_W'(FLOW_PRIO);

   initial begin
      assert (PRIO_W >= 1 && PORT_W >= 1 && QID_W >= 1 && IDX_W >= 1)
         else $error("match_resolver: field widths must be positive");
      assert (ROUTE_PRIO >= 0 && ROUTE_PRIO < (1 << PRIO_W))
         else $error("match_resolver: ROUTE_PRIO does not fit PRIO_W");
      assert (FLOW_PRIO >= 0 && FLOW_PRIO < (1 << PRIO_W))
         else $error("match_resolver: FLOW_PRIO does not fit PRIO_W");
   end

   // ---------------- stage 0: gate and pack candidates ----------------
   logic rt_v, fl_v, wx_v, wn_v;
   assign rt_v = in_valid & rt_hit;
   assign fl_v = in_valid & fl_hit;
   assign wx_v = in_valid & wx_hit;
   assign wn_v = in_valid & wn_hit;

   logic              slot_hit [N_EXCL];
   logic [PRIO_W-1:0] slot_key [N_EXCL];
   logic [ACT_W-1:0]  slot_act [N_EXCL];

   assign slot_hit[SLOT_WILD]  = wx_v;
   assign slot_key[SLOT_WILD]  = wx_prio;
   assign slot_act[SLOT_WILD]  = {wx_port, wx_qid};
   assign slot_hit[SLOT_FLOW]  = fl_v;
   assign slot_key[SLOT_FLOW]  = FL_KEY;
   assign slot_act[SLOT_FLOW]  = {fl_port, fl_qid};
   assign slot_hit[SLOT_ROUTE] = rt_v;
   assign slot_key[SLOT_ROUTE] = RT_KEY;
   assign slot_act[SLOT_ROUTE] = {rt_port, rt_qid};

   logic [N_EXCL-1:0]        c_vld;
   logic [N_EXCL*PRIO_W-1:0] c_key;
   logic [N_EXCL*ACT_W-1:0]  c_act;

   for (genvar g = 0; g < N_EXCL; g++) begin : g_slot
      assign c_vld[g]                  = slot_hit[g];
      assign c_key[g*PRIO_W +: PRIO_W] = slot_key[g];
      assign c_act[g*ACT_W +: ACT_W]   = slot_act[g];
   end

   logic             p_any;
   logic [SEL_W-1:0] p_sel;
   logic [ACT_W-1:0] p_act;

   mr_pick #(.N(N_EXCL), .KEY_W(PRIO_W), .PAY_W(ACT_W)) u_pick (
      .vld     (c_vld),
      .key     (c_key),
      .pay     (c_act),
      .any     (p_any),
      .sel     (p_sel),
      .win_pay (p_act)
   );

   mr_src_e s0_src;
   always_comb begin
      s0_src = SRC_NONE;
      if (p_any) begin
         if (p_sel == SEL_W'(SLOT_WILD))      s0_src = SRC_WILD;
         else if (p_sel == SEL_W'(SLOT_FLOW)) s0_src = SRC_FLOW;
         else                                 s0_src = SRC_ROUTE;
      end
   end

   logic s0_wx_win;
   assign s0_wx_win = p_any && (p_sel == SEL_W'(SLOT_WILD));

   // ---------------- stage 1: resolved set, match-time strobes ----------------
   logic [RF_W-1:0] rf_q;
   mr_pipe #(.W(RF_W)) u_rf_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rt_v, rt_idx, fl_v, fl_idx}),
      .q     (rf_q)
   );
   assign {cnt_rt_inc, cnt_rt_idx, cnt_fl_inc, cnt_fl_idx} = rf_q;

   logic [S1_W-1:0] s1_q;
   mr_pipe #(.W(S1_W)) u_s1_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({in_valid, s0_src, p_act, wn_v, wn_port, wn_qid,
               s0_wx_win, wx_idx, wn_v, wn_idx}),
      .q     (s1_q)
   );

   logic             s1_vld, s1_aux, s1_wx_inc, s1_wn_inc;
   logic [1:0]       s1_src;
   logic [ACT_W-1:0] s1_act, s1_aux_act;
   logic [IDX_W-1:0] s1_wx_idx, s1_wn_idx;
   assign {s1_vld, s1_src, s1_act, s1_aux, s1_aux_act,
           s1_wx_inc, s1_wx_idx, s1_wn_inc, s1_wn_idx} = s1_q;

   logic [1:0] s1_copies;
   logic       s1_drop;
   assign s1_copies = 2'(s1_src != SRC_NONE) + 2'(s1_aux);
   assign s1_drop   = s1_vld && (s1_src == SRC_NONE) && !s1_aux;

   // ---------------- stage 2: registered decision ----------------
   logic [S2_W-1:0] s2_q;
   mr_pipe #(.W(S2_W)) u_s2_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({s1_vld, s1_drop, s1_src, s1_copies, s1_act, s1_aux, s1_aux_act,
               s1_wx_inc, s1_wx_idx, s1_wn_inc, s1_wn_idx}),
      .q     (s2_q)
   );
   assign {dec_valid, dec_drop, dec_src, dec_copies, dec_port, dec_qid,
           aux_valid, aux_port, aux_qid,
           cnt_wx_inc, cnt_wx_idx, cnt_wn_inc, cnt_wn_idx} = s2_q;

endmodule

// File: rtl/mr_check.sv
module mr_check
   import mr_pkg::*;
#(
   parameter int PRIO_W     = 6,
   parameter int QID_W      = 9,
   parameter int ROUTE_PRIO = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              rt_hit,
   input logic              wx_hit,
   input logic [PRIO_W-1:0] wx_prio,
   input logic              wn_hit,
   input logic [QID_W-1:0]  wn_qid,
   input logic              dec_valid,
   input logic              dec_drop,
   input logic [1:0]        dec_src,
   input logic [1:0]        dec_copies,
   input logic              aux_valid,
   input logic [QID_W-1:0]  aux_qid,
   input logic              cnt_rt_inc,
   input logic              cnt_wx_inc,
   input logic              cnt_wn_inc
);

   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) |-> (dec_valid == $past(in_valid, 2)));

   assert_route_loses_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && dec_valid && dec_src == SRC_ROUTE) |->
      (!$past(wx_hit, 2) || $past(wx_prio, 2) > PRIO_W'(ROUTE_PRIO)));

   assert_aux_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && aux_valid) |->
      ($past(wn_hit, 2) && aux_qid == $past(wn_qid, 2)));

   assert_drop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_drop) |->
      (dec_copies == 2'd0 && dec_src == SRC_NONE && !aux_valid));

   assert_route_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1) |-> (cnt_rt_inc == $past(in_valid && rt_hit)));

   assert_wx_strobe_win_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wx_inc |-> (dec_valid && dec_src == SRC_WILD));

   assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!aux_valid && !cnt_wx_inc && !cnt_wn_inc));

endmodule

bind match_resolver mr_check #(
   .PRIO_W     (PRIO_W),
   .QID_W      (QID_W),
   .ROUTE_PRIO (ROUTE_PRIO)
) u_mr_check (.*);

// File: tb/match_resolver_bench.sv
module match_resolver_bench;

   localparam int PRIO_W = 6;
   localparam int PORT_W = 3;
   localparam int QID_W  = 9;
   localparam int IDX_W  = 6;
   localparam int RP     = 20;
   localparam int FP     = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              in_valid = 0, rt_hit = 0, fl_hit = 0, wx_hit = 0, wn_hit = 0;
   logic [PRIO_W-1:0] wx_prio = '0;
   logic [PORT_W-1:0] rt_port = '0, fl_port = '0, wx_port = '0, wn_port = '0;
   logic [QID_W-1:0]  rt_qid = '0, fl_qid = '0, wx_qid = '0, wn_qid = '0;
   logic [IDX_W-1:0]  rt_idx = '0, fl_idx = '0, wx_idx = '0, wn_idx = '0;

   logic              dec_valid, dec_drop, aux_valid;
   logic [1:0]        dec_src, dec_copies;
   logic [PORT_W-1:0] dec_port, aux_port;
   logic [QID_W-1:0]  dec_qid, aux_qid;
   logic              cnt_rt_inc, cnt_fl_inc, cnt_wx_inc, cnt_wn_inc;
   logic [IDX_W-1:0]  cnt_rt_idx, cnt_fl_idx, cnt_wx_idx, cnt_wn_idx;

   match_resolver #(
      .PRIO_W(PRIO_W), .PORT_W(PORT_W), .QID_W(QID_W), .IDX_W(IDX_W),
      .ROUTE_PRIO(RP), .FLOW_PRIO(FP)
   ) u_match_resolver (.*);

   typedef struct {
      int v, rt_inc, rt_idx, fl_inc, fl_idx;
      int src, port, qid, drop, copies;
      int aux, aux_port, aux_qid, wx_inc, wx_idx, wn_inc, wn_idx;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 0;

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   // Driver: called at posedge+1, applies one set, pushes its expectation after sampling.
   task automatic drive(input bit v, input bit rh, input bit fh, input bit xh,
                        input bit nh, input int xp, input int tag);
      exp_t e;
      int   s;
      in_valid = v;  rt_hit = rh; fl_hit = fh; wx_hit = xh; wn_hit = nh;
      wx_prio  = PRIO_W'(xp);
      rt_port  = PORT_W'(tag);     fl_port = PORT_W'(tag + 1);
      wx_port  = PORT_W'(tag + 2); wn_port = PORT_W'(tag + 3);
      rt_qid   = QID_W'(8 + (tag * 4) % 120);
      fl_qid   = QID_W'(8 + (tag * 4 + 1) % 120);
      wx_qid   = QID_W'(8 + (tag * 4 + 2) % 120);
      wn_qid   = QID_W'(8 + (tag * 4 + 3) % 120);
      rt_idx   = IDX_W'(tag);      fl_idx = IDX_W'(tag + 7);
      wx_idx   = IDX_W'(tag + 14); wn_idx = IDX_W'(tag + 21);
      // expectation from the requirements
      s = 0;
      if (v) begin
         if (xh && (!fh || xp <= FP) && (!rh || xp <= RP)) s = 3;
         else if (fh && (!rh || FP <= RP))                 s = 2;
         else if (rh)                                      s = 1;
      end
      e.v      = v;
      e.rt_inc = v && rh;  e.rt_idx = int'(rt_idx);
      e.fl_inc = v && fh;  e.fl_idx = int'(fl_idx);
      e.src    = s;
      e.port   = (s == 3) ? int'(wx_port) : (s == 2) ? int'(fl_port) : int'(rt_port);
      e.qid    = (s == 3) ? int'(wx_qid)  : (s == 2) ? int'(fl_qid)  : int'(rt_qid);
      e.aux    = v && nh;
      e.aux_port = int'(wn_port); e.aux_qid = int'(wn_qid);
      e.copies = ((s != 0) ? 1 : 0) + (e.aux ? 1 : 0);
      e.drop   = (v && s == 0 && !e.aux) ? 1 : 0;
      e.wx_inc = (s == 3) ? 1 : 0; e.wx_idx = int'(wx_idx);
      e.wn_inc = e.aux;            e.wn_idx = int'(wn_idx);
      @(posedge clk);
      #1;
      q.push_back(e);
   endtask

   task automatic check_strobes(input exp_t e);
      chk("R8", "cnt_rt_inc", int'(cnt_rt_inc), e.rt_inc);
      chk("R8", "cnt_fl_inc", int'(cnt_fl_inc), e.fl_inc);
      if (e.rt_inc != 0) chk("R8", "cnt_rt_idx", int'(cnt_rt_idx), e.rt_idx);
      if (e.fl_inc != 0) chk("R8", "cnt_fl_idx", int'(cnt_fl_idx), e.fl_idx);
   endtask

   task automatic check_decision(input exp_t e);
      chk("R1", "dec_valid", int'(dec_valid), e.v);
      if (e.v == 0) begin
         chk("R11", "aux_valid", int'(aux_valid), 0);
         chk("R11", "cnt_wx_inc", int'(cnt_wx_inc), 0);
         chk("R11", "cnt_wn_inc", int'(cnt_wn_inc), 0);
         return;
      end
      chk("R2_R3", "dec_src", int'(dec_src), e.src);
      if (e.src != 0) begin
         chk("R4", "dec_port", int'(dec_port), e.port);
         chk("R4", "dec_qid", int'(dec_qid), e.qid);
      end
      chk("R6", "dec_drop", int'(dec_drop), e.drop);
      chk("R5_R7", "dec_copies", int'(dec_copies), e.copies);
      chk("R5", "aux_valid", int'(aux_valid), e.aux);
      if (e.aux != 0) begin
         chk("R5", "aux_port", int'(aux_port), e.aux_port);
         chk("R5", "aux_qid", int'(aux_qid), e.aux_qid);
      end
      chk("R9", "cnt_wx_inc", int'(cnt_wx_inc), e.wx_inc);
      if (e.wx_inc != 0) chk("R9", "cnt_wx_idx", int'(cnt_wx_idx), e.wx_idx);
      chk("R10", "cnt_wn_inc", int'(cnt_wn_inc), e.wn_inc);
      if (e.wn_inc != 0) chk("R10", "cnt_wn_idx", int'(cnt_wn_idx), e.wn_idx);
   endtask

   // Monitor: strobes one cycle after sampling, decision one cycle later.
   initial begin
      exp_t pend, cur;
      bit   have = 0;
      forever begin
         @(negedge clk);
         if (have) check_decision(pend);
         have = 0;
         if (q.size() > 0) begin
            cur = q.pop_front();
            check_strobes(cur);
            pend = cur;
            have = 1;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: reset state
      chk("R12", "dec_valid", int'(dec_valid), 0);
      chk("R12", "dec_copies", int'(dec_copies), 0);
      chk("R12", "aux_valid", int'(aux_valid), 0);
      chk("R12", "strobes", int'({cnt_rt_inc, cnt_fl_inc, cnt_wx_inc, cnt_wn_inc}), 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      //      v  rt fl wx wn prio tag
      drive(1, 1, 0, 0, 0, 0,  1);   // R4 route only
      drive(1, 1, 1, 0, 0, 0,  2);   // R3 flow beats route on equal common priority
      drive(1, 1, 1, 1, 0, 19, 3);   // R2 wildcard more urgent
      drive(1, 1, 1, 1, 0, 21, 4);   // R2 wildcard less urgent, flow wins, R8 both strobes
      drive(1, 1, 1, 1, 0, 20, 5);   // R3 three-way tie, wildcard wins
      drive(1, 1, 0, 1, 0, 63, 6);   // R2 route beats weak wildcard
      drive(1, 0, 0, 1, 0, 0,  7);   // R9 wildcard alone at priority 0
      drive(1, 0, 0, 0, 1, 5,  8);   // R7 only non-exclusive
      drive(1, 0, 0, 0, 0, 0,  9);   // R6 nothing matched
      drive(1, 1, 0, 1, 1, 2,  10);  // R5 two copies, R10 strobe
      drive(1, 1, 1, 1, 1, 50, 11);  // R5 copy regardless of priority, R9 no wx strobe
      drive(0, 1, 1, 1, 1, 0,  12);  // R11 hits without in_valid
      drive(0, 0, 0, 0, 0, 0,  13);
      drive(1, 0, 1, 0, 0, 0,  14);  // R1 restart after gap
      for (int i = 0; i < 80; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[0] | lfsr[7], lfsr[1], lfsr[2], lfsr[3], lfsr[4],
               int'(lfsr[15:10]), 20 + i);
      end
      repeat (3) drive(0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      @(negedge clk);
      done = 1;
      report();
   end

endmodule